// File: doc/BRIEF.md
# Thermocouple Converter Serial Reader

This block is a serial-bus master that reads one temperature sample from a thermocouple-to-digital converter each time a start pulse is accepted. It lowers an active-low chip select and produces a serial clock that idles low, with the first edge rising. It captures the first 16 bits the converter shifts out, most significant bit first, and then releases chip select. The remaining bits of the converter's frame are never clocked out.

The 14-bit temperature in those bits is split three ways. A 4-bit upper integer part and an 8-bit lower integer part are passed through unchanged. The two fractional bits become a decimal hundredths code of 0, 25, 50 or 75. When the results are loaded, a one-cycle ready strobe is raised. A busy output tells the requester that the engine is in a transfer. A bus-busy input reports traffic to another slave on the same bus, and start requests are refused while it is high. The serial clock half-period is a whole number of system clock cycles, set by a parameter.

Top module: `tc_spi_reader`

## Requirements
- R1: While reset is high and in the first cycle after it: cs_n_o=1, sclk_o=0, busy_o=0, ready_o=0, and temp_hi_o, temp_lo_o and frac_o are all 0.
- R2: A start_i pulse sampled while busy_o=0 and bus_busy_i=0 is accepted. At that same clock edge cs_n_o goes to 0 and busy_o goes to 1.
- R3: sclk_o is 0 whenever cs_n_o is 1. After chip select falls, sclk_o stays low for HALF_DIV cycles, and its first transition is rising.
- R4: Each transfer makes exactly 16 rising edges of sclk_o, each HALF_DIV cycles wide. miso_i is sampled at every rising edge, and the first sampled bit is the most significant bit (received bit 15).
- R5: mosi_o is 0 at all times.
- R6: ready_o is high for exactly one cycle. It rises at the clock edge (2*16+1)*HALF_DIV cycles after the accepting edge. At that same edge cs_n_o returns to 1 and busy_o returns to 0.
- R7: temp_hi_o equals received bits 15..12, and temp_lo_o equals received bits 11..4. Received bits 1..0 have no effect on any output.
- R8: frac_o is set from received bits 3..2: 00 gives 0, 01 gives 25, 10 gives 50, 11 gives 75.
- R9: A start_i pulse that arrives while busy_o=1 is ignored and not queued. After the transfer ends, no new transfer begins.
- R10: A start_i pulse that arrives while bus_busy_i=1 is ignored. cs_n_o and busy_o do not change, and no later transfer follows from it.
- R11: temp_hi_o, temp_lo_o and frac_o change only in the cycle where ready_o is high. At all other times they hold the last completed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one sample |
| bus_busy_i | input | 1 | Another slave on the shared bus is being served |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to the slave, always 0 |
| busy_o | output | 1 | Transfer in progress |
| temp_hi_o | output | 4 | Upper integer temperature bits |
| temp_lo_o | output | 8 | Lower integer temperature bits |
| frac_o | output | 7 | Fraction in hundredths of a degree: 0, 25, 50 or 75 |
| ready_o | output | 1 | One-cycle strobe marking new results |

## Verification
Suppose the edge counter or the divider holds a wrong value. The count of sclk_o rises seen inside one chip-select window would then differ from 16, or ready_o would appear at a cycle other than 33 half-periods after acceptance. Both show up within that single transfer. A misaligned shift register or a wrong field slice shows up first on the ready strobe of the affected sample, as wrong integer or fraction values. The frame patterns are chosen to separate neighbouring bit positions, so this kind of fault cannot hide. A control state that fails to go back to idle shows up as busy_o or cs_n_o stuck low once the expected end of the transfer has passed.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } tc_state_e;

  localparam int unsigned FRAC_STEP = 25;
endpackage

// File: rtl/tc_sclk_gen.sv
// Half-period tick generator for the serial clock.
module tc_sclk_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/tc_rx_shift.sv
// MSB-first receive shift register.
module tc_rx_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
    end else if (shift_en) begin
      data <= {data[WIDTH-2:0], din};
    end
  end
endmodule

// File: rtl/tc_frac_decode.sv
// Two fractional bits to a hundredths code.
module tc_frac_decode #(
  parameter int FRAC_W = 7
) (
  input  logic [1:0]        bits,
  output logic [FRAC_W-1:0] code
);
  localparam logic [FRAC_W-1:0] STEP = FRAC_W'(tc_pkg::FRAC_STEP);

  always_comb begin
    code = FRAC_W'(bits) * STEP;
  end
endmodule

// File: rtl/tc_spi_reader.sv
module tc_spi_reader #(
  parameter int HALF_DIV   = 4,
  parameter int FRAME_BITS = 16,
  parameter int INT_HI_W   = 4,
  parameter int INT_LO_W   = 8,
  parameter int FRAC_W     = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                bus_busy_i,
  input  logic                miso_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic                busy_o,
  output logic [INT_HI_W-1:0] temp_hi_o,
  output logic [INT_LO_W-1:0] temp_lo_o,
  output logic [FRAC_W-1:0]   frac_o,
  output logic                ready_o
);
  import tc_pkg::*;

  localparam int EDGE_END = 2 * FRAME_BITS;
  localparam int EW       = $clog2(EDGE_END + 1);
  localparam int HI_TOP   = FRAME_BITS - 1;
  localparam int LO_TOP   = HI_TOP - INT_HI_W;
  localparam int FR_TOP   = LO_TOP - INT_LO_W;

  tc_state_e           state_q;
  logic [EW-1:0]       edge_q;
  logic                sclk_q;
  logic                cs_n_q;
  logic                ready_q;
  logic [INT_HI_W-1:0] hi_q;
  logic [INT_LO_W-1:0] lo_q;
  logic [FRAC_W-1:0]   frac_q;

  logic                  run;
  logic                  tick;
  logic                  shift_en;
  logic [FRAME_BITS-1:0] rx;
  logic [FRAC_W-1:0]     frac_dec;

  assign run      = (state_q == ST_XFER);
  assign shift_en = tick && !edge_q[0] && (edge_q < EW'(EDGE_END));

  tc_sclk_gen #(.HALF_DIV(HALF_DIV)) sclk_gen_i (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .tick (tick)
  );

  tc_rx_shift #(.WIDTH(FRAME_BITS)) rx_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .din      (miso_i),
    .data     (rx)
  );

  tc_frac_decode #(.FRAC_W(FRAC_W)) frac_i (
    .bits (rx[FR_TOP -: 2]),
    .code (frac_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      ready_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
      frac_q  <= '0;
    end else begin
      ready_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i && !bus_busy_i) begin
            state_q <= ST_XFER;
            cs_n_q  <= 1'b0;
            edge_q  <= '0;
            sclk_q  <= 1'b0;
          end
        end
        ST_XFER: begin
          if (tick) begin
            if (edge_q == EW'(EDGE_END)) begin
              state_q <= ST_IDLE;
              cs_n_q  <= 1'b1;
              ready_q <= 1'b1;
              hi_q    <= rx[HI_TOP -: INT_HI_W];
              lo_q    <= rx[LO_TOP -: INT_LO_W];
              frac_q  <= frac_dec;
            end else begin
              edge_q <= edge_q + 1'b1;
              sclk_q <= ~edge_q[0];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o    = cs_n_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = 1'b0;
  assign busy_o    = run;
  assign temp_hi_o = hi_q;
  assign temp_lo_o = lo_q;
  assign frac_o    = frac_q;
  assign ready_o   = ready_q;
endmodule

// File: rtl/tc_spi_reader_chk.sv
module tc_spi_reader_chk #(
  parameter int FRAME_BITS = 16,
  parameter int INT_HI_W   = 4,
  parameter int INT_LO_W   = 8,
  parameter int FRAC_W     = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                bus_busy_i,
  input logic                cs_n_o,
  input logic                sclk_o,
  input logic                busy_o,
  input logic [INT_HI_W-1:0] temp_hi_o,
  input logic [INT_LO_W-1:0] temp_lo_o,
  input logic [FRAC_W-1:0]   frac_o,
  input logic                ready_o
);
  localparam int RW = $clog2(FRAME_BITS + 2);

  logic          sclk_d;
  logic [RW-1:0] rises;

  always_ff @(posedge clk) begin
    if (rst || cs_n_o) begin
      sclk_d <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o && !sclk_d) rises <= rises + 1'b1;
    end
  end

  // R3
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  // R4
  rise_limit_chk: assert property (@(posedge clk) disable iff (rst)
    rises <= RW'(FRAME_BITS));

  // R4
  full_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(rises) == RW'(FRAME_BITS));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !bus_busy_i) |=> (busy_o && !cs_n_o));

  // R10
  bus_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && bus_busy_i) |=> (!busy_o && cs_n_o));

  // R6
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);

  // R6
  ready_release_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (cs_n_o && !busy_o));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ready_o |-> ($stable(temp_hi_o) && $stable(temp_lo_o) && $stable(frac_o)));
endmodule

bind tc_spi_reader tc_spi_reader_chk #(
  .FRAME_BITS(FRAME_BITS), .INT_HI_W(INT_HI_W), .INT_LO_W(INT_LO_W), .FRAC_W(FRAC_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .bus_busy_i (bus_busy_i),
  .cs_n_o     (cs_n_o),
  .sclk_o     (sclk_o),
  .busy_o     (busy_o),
  .temp_hi_o  (temp_hi_o),
  .temp_lo_o  (temp_lo_o),
  .frac_o     (frac_o),
  .ready_o    (ready_o)
);

// File: tb/tc_spi_reader_tb_top.sv
module tc_spi_reader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 4;
  localparam int LATENCY    = (2 * 16 + 1) * HALF_DIV + 1;
  localparam int NVEC       = 6;

  // {frame[15:0], hi[3:0], lo[7:0], frac[6:0]}
  localparam logic [34:0] VEC [NVEC] = '{
    {16'h0000, 4'h0, 8'h00, 7'd0},
    {16'h1934, 4'h1, 8'h93, 7'd25},
    {16'hFFFF, 4'hF, 8'hFF, 7'd75},
    {16'hA5AA, 4'hA, 8'h5A, 7'd50},
    {16'h064D, 4'h0, 8'h64, 7'd75},
    {16'h8003, 4'h8, 8'h00, 7'd0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       bus_busy_i = 1'b0;
  logic       miso_i = 1'b0;
  logic       cs_n_o, sclk_o, mosi_o, busy_o, ready_o;
  logic [3:0] temp_hi_o;
  logic [7:0] temp_lo_o;
  logic [6:0] frac_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] tx_frame = '0;
  int          bit_idx  = 0;
  int          rise_cnt = 0;
  int          mosi_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_spi_reader #(.HALF_DIV(HALF_DIV)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .bus_busy_i(bus_busy_i),
    .miso_i(miso_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .busy_o(busy_o), .temp_hi_o(temp_hi_o), .temp_lo_o(temp_lo_o),
    .frac_o(frac_o), .ready_o(ready_o)
  );

  // Converter model: first bit valid at chip-select fall, next bit on each falling clock.
  always @(negedge cs_n_o) begin
    bit_idx  = 15;
    rise_cnt = 0;
    miso_i   = tx_frame[15];
  end
  always @(negedge sclk_o) begin
    if (!cs_n_o && bit_idx > 0) begin
      bit_idx = bit_idx - 1;
      miso_i  = tx_frame[bit_idx];
    end
  end
  always @(posedge sclk_o) if (!cs_n_o) rise_cnt = rise_cnt + 1;
  always @(negedge clk) if (mosi_o !== 1'b0) mosi_bad = mosi_bad + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // One full transfer; checks acceptance, timing and edge count.
  task automatic run_frame(input logic [15:0] frame);
    int cyc;
    tx_frame = frame;
    pulse_start();
    check("R2 cs_n after accept", cs_n_o, 0);
    check("R2 busy after accept", busy_o, 1);
    cyc = 1;
    for (int i = 0; i < HALF_DIV - 1; i++) begin
      @(negedge clk); cyc++;
      check("R3 sclk low in lead-in", sclk_o, 0);
    end
    while (!ready_o && cyc < LATENCY + 20) begin
      @(negedge clk); cyc++;
    end
    check("R6 ready latency", cyc, LATENCY);
    check("R6 cs_n at ready", cs_n_o, 1);
    check("R6 busy at ready", busy_o, 0);
    check("R4 rising edges", rise_cnt, 16);
    @(negedge clk);
    check("R6 ready one cycle", ready_o, 0);
  endtask

  initial begin
    logic [3:0] h0;
    logic [7:0] l0;
    logic [6:0] f0;
    repeat (3) @(negedge clk);
    check("R1 cs_n in reset", cs_n_o, 1);
    check("R1 sclk in reset", sclk_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", busy_o, 0);
    check("R1 ready", ready_o, 0);
    check("R1 outputs", {temp_hi_o, temp_lo_o, frac_o}, 0);

    for (int v = 0; v < NVEC; v++) begin
      run_frame(VEC[v][34:19]);
      check("R7 temp_hi", temp_hi_o, VEC[v][18:15]);
      check("R7 temp_lo", temp_lo_o, VEC[v][14:7]);
      check("R8 frac", frac_o, VEC[v][6:0]);
      repeat (5) @(negedge clk);
      check("R11 hold hi/lo", {temp_hi_o, temp_lo_o}, VEC[v][18:7]);
      check("R11 hold frac", frac_o, VEC[v][6:0]);
    end

    // R7: two low bits have no effect
    run_frame(16'h3C51);
    h0 = temp_hi_o; l0 = temp_lo_o; f0 = frac_o;
    run_frame(16'h3C52);
    check("R7 low bits ignored", {temp_hi_o, temp_lo_o, frac_o}, {h0, l0, f0});
    check("R8 frac 00", f0, 0);

    // R9: start during a transfer is dropped
    tx_frame = 16'h7E9C;
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    while (!ready_o) @(negedge clk);
    check("R9 data of first request", {temp_hi_o, temp_lo_o}, 12'h7E9);
    for (int i = 0; i < 3 * HALF_DIV + 5; i++) @(negedge clk);
    check("R9 no queued transfer busy", busy_o, 0);
    check("R9 no queued transfer cs", cs_n_o, 1);

    // R10: start while another slave owns the bus
    bus_busy_i = 1'b1;
    tx_frame = 16'h0000;
    pulse_start();
    repeat (2) @(negedge clk);
    check("R10 cs_n unchanged", cs_n_o, 1);
    check("R10 busy unchanged", busy_o, 0);
    bus_busy_i = 1'b0;
    repeat (HALF_DIV * 4) @(negedge clk);
    check("R10 no late transfer", cs_n_o, 1);
    check("R11 held after refused start", {temp_hi_o, temp_lo_o}, 12'h7E9);

    check("R5 mosi always zero", mosi_bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule